// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs single PHY management transactions over the two-wire MDC/MDIO bus. Host logic sees two 16-bit registers: a command word and a data word. For a write transaction, the data word is loaded first. Writing the command word then names the PHY, the register inside the PHY and the direction, and starts a complete management frame at once.

The engine builds the whole frame from the command word. It clocks the frame out on MDC, which is derived from the system clock. On a read, it releases the data line for the turnaround and data phases and gathers the sixteen bits the PHY returns. When the frame ends, it sets a sticky finish flag in the command word. Software polls this flag before it issues a command, and polls it again to learn that the result is ready.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset the command word reads 16'h8000 (finish flag in bit 15 set, all other fields zero), the data word reads 0, MDC is low and the MDIO output enable is low; while the finish flag is set, MDC stays low and the output enable stays low.
- R2: A command-word write (select 0) made while the finish flag is set clears the flag on the next cycle and latches the fields: bit 13 = write (1) or read (0), bits 12:8 = PHY address, bits 4:0 = register number; bits 14, 7:5 read as zero.
- R3: Each frame starts, MSB first, with 32 ones, then the start pattern 01, then opcode 01 for a write or 10 for a read, then the 5-bit PHY address and the 5-bit register number.
- R4: In a write frame the turnaround bits are 10, followed by the 16 bits of the data word MSB first, and the output enable stays high for all 64 bit periods.
- R5: In a read frame the output enable is low from bit 46 (the first turnaround bit) to the end of the frame; the 16 bits sampled on the rising MDC edges of bits 48 to 63 (MSB first) become the data word when the frame ends.
- R6: One MDC period lasts DIV system clocks (half low, half high); MDIO output changes only when MDC falls, never while MDC stays high.
- R7: The finish flag is set again exactly 64*DIV clock cycles after the command write, at the falling MDC edge that closes bit 63.
- R8: While the finish flag is clear, writes to either register are ignored, including a data write in the very cycle the frame completes; the command fields and, for a write frame, the data word read back unchanged.
- R9: A data-word write (select 1) while the finish flag is set updates the data word on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | Register select: 0 command word, 1 data word |
| wr_data | input | 16 | Host write value |
| cmd_rdata | output | 16 | Command word read-back, finish flag in bit 15 |
| data_rdata | output | 16 | Data word read-back |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
Two events can meet in one cycle: completion of a read frame, which loads the captured PHY bits into the data word, and a host write to that same data word. The bench provokes this by timing a data write to land on the clock edge 64*DIV cycles after the command write, which is the edge where the read completes. The data word must then hold the value the modelled PHY returned, not the host value. A second collision case rewrites both registers in the middle of a frame, and the frame shape and the read-back fields must not change.

// File: rtl/mdio_cmd_pkg.sv
// Package: shared constants and frame construction for the MDIO command engine.
// Assumes a fixed 64-bit management frame and the 16-bit command word layout.
package mdio_cmd_pkg;
    localparam int FRAME_LEN = 64;
    localparam int PRE_LEN   = 32;
    localparam int TA_IDX    = 46;
    localparam int DATA_IDX  = 48;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int WORD_W    = 16;
    localparam int ADR_W     = 5;
    localparam int WR_BIT    = 13;
    localparam int FIN_BIT   = 15;

    typedef enum logic {
        SEL_CMD  = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    // Builds the full outgoing frame; read frames carry ones where the PHY drives
    function automatic logic [FRAME_LEN-1:0] build_frame(
        input logic              is_wr,
        input logic [ADR_W-1:0]  phy,
        input logic [ADR_W-1:0]  regn,
        input logic [WORD_W-1:0] wdat
    );
        logic [1:0] op;
        logic [1:0] ta;
        logic [WORD_W-1:0] body;
        op   = is_wr ? 2'b01 : 2'b10;
        ta   = is_wr ? 2'b10 : 2'b11;
        body = is_wr ? wdat : {WORD_W{1'b1}};
        return {{PRE_LEN{1'b1}}, 2'b01, op, phy, regn, ta, body};
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: MDC generator. Divides the system clock by DIV while run is high and
// flags the clock cycle in which MDC rises or falls.
// Assumes DIV is even and at least 4; MDC is held low while run is low.
module mdio_mdc_gen #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          toggle_now;

    assign toggle_now = run && (cnt == CW'(HALF - 1));
    assign rise_stb   = toggle_now && !mdc;
    assign fall_stb   = toggle_now && mdc;

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (toggle_now) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer. Loads a 64-bit frame on start, shifts one bit per
// falling MDC edge, releases the line for the read turnaround and data phases,
// and gathers read bits on rising MDC edges.
// Assumes start is only raised while idle.
module mdio_frame_seq
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic [ADR_W-1:0]  start_phy,
    input  logic [ADR_W-1:0]  start_reg,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              rd_mode,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [WORD_W-1:0] rd_word,
    output logic              finish
);
    logic [FRAME_LEN-1:0] shreg;
    logic [IDX_W-1:0]     next_idx;
    logic                 last_bit;

    assign last_bit = (bit_idx == IDX_W'(FRAME_LEN - 1));
    assign next_idx = bit_idx + 1'b1;
    assign finish   = busy && fall_stb && last_bit;

    // Frame shift register, bit index and line drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            busy    <= 1'b0;
            rd_mode <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (start) begin
            shreg   <= build_frame(start_wr, start_phy, start_reg, wdata);
            bit_idx <= '0;
            busy    <= 1'b1;
            rd_mode <= !start_wr;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
        end else if (busy && fall_stb) begin
            if (last_bit) begin
                busy    <= 1'b0;
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b0;
            end else begin
                bit_idx <= next_idx;
                shreg   <= {shreg[FRAME_LEN-2:0], 1'b1};
                mdio_o  <= shreg[FRAME_LEN-2];
                mdio_oe <= !(rd_mode && (next_idx >= IDX_W'(TA_IDX)));
            end
        end
    end

    // Read data capture on rising MDC during the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (busy && rise_stb && rd_mode && (bit_idx >= IDX_W'(DATA_IDX))) begin
            rd_word <= {rd_word[WORD_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_cmd_engine.sv
// Module: top of the MDIO management command engine. Holds the command and data
// words, starts a frame on a command write while idle, and sets the sticky
// finish flag when the frame ends.
// Assumes software polls the finish flag; writes made while busy are dropped.
module mdio_cmd_engine
    import mdio_cmd_pkg::*;
#(
    parameter int DIV = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    output logic [15:0] cmd_rdata,
    output logic [15:0] data_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              fin_flag;
    logic              cmd_wr;
    logic [ADR_W-1:0]  cmd_phy;
    logic [ADR_W-1:0]  cmd_reg;
    logic [WORD_W-1:0] data_q;
    logic              start;
    logic              data_wr;
    logic              busy;
    logic              rd_mode;
    logic [IDX_W-1:0]  bit_idx;
    logic [WORD_W-1:0] rd_word;
    logic              finish;
    logic              rise_stb;
    logic              fall_stb;

    assign start   = wr_en && (wr_sel == SEL_CMD) && fin_flag;
    assign data_wr = wr_en && (wr_sel == SEL_DATA) && fin_flag;

    assign cmd_rdata  = {fin_flag, 1'b0, cmd_wr, cmd_phy, 3'b000, cmd_reg};
    assign data_rdata = data_q;

    // Command word fields and finish flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_flag <= 1'b1;
            cmd_wr   <= 1'b0;
            cmd_phy  <= '0;
            cmd_reg  <= '0;
        end else if (start) begin
            fin_flag <= 1'b0;
            cmd_wr   <= wr_data[WR_BIT];
            cmd_phy  <= wr_data[8 +: ADR_W];
            cmd_reg  <= wr_data[0 +: ADR_W];
        end else if (finish) begin
            fin_flag <= 1'b1;
        end
    end

    // Data word: host load when idle, read result at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_wr) begin
            data_q <= wr_data;
        end else if (finish && rd_mode) begin
            data_q <= rd_word;
        end
    end

    mdio_mdc_gen #(.DIV(DIV)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_wr  (wr_data[WR_BIT]),
        .start_phy (wr_data[8 +: ADR_W]),
        .start_reg (wr_data[0 +: ADR_W]),
        .wdata     (data_q),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .rd_mode   (rd_mode),
        .bit_idx   (bit_idx),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_word   (rd_word),
        .finish    (finish)
    );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
// Module: assertion checker for the MDIO command engine, bound to the top.
// Assumes the synchronous active-low reset of the top module.
module mdio_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [15:0] cmd_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        rd_mode,
    input logic [5:0]  bit_idx
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[15] |-> (!mdio_oe && !mdc));

    // R2
    fin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && cmd_rdata[15]) |=> !cmd_rdata[15]);

    // R4
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_mode) |-> mdio_oe);

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_mode && (bit_idx >= 6'd46)) |-> !mdio_oe);

    // R6
    mdo_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rdata[15] && $past(!cmd_rdata[15])) |-> $stable(cmd_rdata[14:0]));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .rd_mode   (rd_mode),
    .bit_idx   (bit_idx)
);

// File: tb/mdio_cmd_engine_bench.sv
// Bench: scoreboard. The driver task queues the expected frame for each
// transaction; a PHY-model monitor pops it and compares the frame on the wire.
module mdio_cmd_engine_bench;
    localparam int CLK_P     = 10;
    localparam int DIV       = 20;
    localparam int FRAME_CYC = 64 * DIV;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        wr_sel;
    logic [15:0] wr_data;
    logic [15:0] cmd_rdata;
    logic [15:0] data_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        bit          wr;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] val;
    } item_t;
    item_t sb_q[$];

    mdio_cmd_engine #(.DIV(DIV)) u_mdio_cmd_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .cmd_rdata  (cmd_rdata),
        .data_rdata (data_rdata),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_i)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input bit sel, input logic [15:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // mode 0: plain, 1: data write on the completion edge, 2: writes mid-frame
    task automatic run_cmd(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] val, input int mode);
        int cnt;
        logic [15:0] cword;
        item_t it;
        cword = {2'b00, wr, phy, 3'b000, ra};
        if (wr) host_wr(1'b1, val);
        it.wr = wr; it.phy = phy; it.ra = ra; it.val = val;
        sb_q.push_back(it);
        host_wr(1'b0, cword);
        check(cmd_rdata == cword, "R2 command fields latched, flag clear", cmd_rdata, cword);
        cnt = 0;
        while (!cmd_rdata[15] && cnt < FRAME_CYC + 50) begin
            if (mode == 1 && cnt == FRAME_CYC - 1) begin
                wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'hDEAD;
            end else if (mode == 2 && cnt == 100) begin
                wr_en = 1'b1; wr_sel = 1'b0; wr_data = {2'b00, ~wr, ~phy, 3'b000, ~ra};
            end else if (mode == 2 && cnt == 101) begin
                wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h5A5A;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        wr_en = 1'b0;
        check(cnt == FRAME_CYC, "R7 finish flag timing", cnt, FRAME_CYC);
        check(cmd_rdata == {1'b1, cword[14:0]}, "R8 command fields held", cmd_rdata,
              {1'b1, cword[14:0]});
        if (wr)
            check(data_rdata == val, "R8 data word kept through write frame", data_rdata, val);
        else
            check(data_rdata == val, "R5 R8 read result in data word", data_rdata, val);
        repeat (5) @(negedge clk);
    endtask

    // PHY model and scoreboard monitor
    initial begin : monitor
        item_t it;
        logic [63:0] frm;
        logic [63:0] oes;
        logic [63:0] exp_frm;
        int per_bad;
        time tlast;
        time tnow;
        mdio_i = 1'b1;
        forever begin
            @(posedge mdio_oe);
            #1;
            if (sb_q.size() == 0) begin
                check(1'b0, "R3 frame with no queued item", 0, 1);
            end else begin
                it = sb_q.pop_front();
                frm = '0; oes = '0; per_bad = 0; tlast = 0;
                for (int r = 0; r < 64; r++) begin
                    @(posedge mdc);
                    #1;
                    tnow = $time;
                    if (r > 0 && (tnow - tlast) != DIV * CLK_P) per_bad++;
                    tlast = tnow;
                    frm = {frm[62:0], mdio_o};
                    oes = {oes[62:0], mdio_oe};
                    if (!it.wr && r >= 47 && r < 63) mdio_i = it.val[62 - r];
                    else if (r == 63) mdio_i = 1'b1;
                end
                exp_frm = {32'hFFFF_FFFF, 2'b01, (it.wr ? 2'b01 : 2'b10), it.phy, it.ra,
                           2'b10, it.val};
                check(frm[63:18] == exp_frm[63:18], "R3 frame header", frm[63:18], exp_frm[63:18]);
                if (it.wr) begin
                    check(frm[17:0] == exp_frm[17:0], "R4 write turnaround and data",
                          frm[17:0], exp_frm[17:0]);
                    check(oes == '1, "R4 output enable held", oes, 64'hFFFF_FFFF_FFFF_FFFF);
                end else begin
                    check(oes == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5 line released in read",
                          oes, {46'h3FFF_FFFF_FFFF, 18'h0});
                end
                check(per_bad == 0, "R6 MDC period", per_bad, 0);
            end
        end
    end

    initial begin : watchdog
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : driver
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        check(cmd_rdata == 16'h8000, "R1 command word after reset", cmd_rdata, 16'h8000);
        check(data_rdata == 16'h0, "R1 data word after reset", data_rdata, 0);
        check({mdc, mdio_oe} == 2'b00, "R1 bus idle after reset", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        host_wr(1'b1, 16'h1234);
        check(data_rdata == 16'h1234, "R9 data word load while idle", data_rdata, 16'h1234);
        check({mdc, mdio_oe} == 2'b00, "R1 data load starts no frame", {mdc, mdio_oe}, 0);
        run_cmd(1'b1, 5'h01, 5'h00, 16'hA5C3, 0);
        run_cmd(1'b0, 5'h1F, 5'h1F, 16'h8001, 0);
        run_cmd(1'b0, 5'h00, 5'h11, 16'h7FFE, 1);
        run_cmd(1'b1, 5'h12, 5'h09, 16'h0000, 2);
        run_cmd(1'b0, 5'h0A, 5'h15, 16'hFFFF, 2);
        check(sb_q.size() == 0, "R3 every queued frame seen", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule